// File: doc/BRIEF.md
# Software-Loaded TLB Controller

This block is a small fully associative address translation cache whose contents are managed entirely by software. Software stages a virtual page tag, a physical page number, attribute bits and a preserve flag on dedicated inputs. It points a slot pointer at an entry and pulses a load strobe to commit the staged values. The same pointer selects the entry that is returned on two readback words, one for the tag side and one for the data side. A base value keeps the lowest slots out of the automatic pointer rotation, so they cannot be overwritten by it. Entries can be dropped all at once (preserved ones survive) or one at a time by virtual page, whatever their preserve flag.

On the lookup side, a requester presents a virtual address. One cycle later the block returns the translated physical address or a fault. A lookup that finds no entry is a miss, and one that finds two or more is a multi-hit. Either fault sets a sticky status bit, records the faulting address and raises an interrupt if that fault is enabled. The block also stops accepting requests until software clears every pending status bit. With translation disabled, addresses pass through unchanged and never fault. Pages have a single fixed size.

Top module: `sw_tlb`

## Requirements
- R1: A load strobe writes the staged tag, page number, attribute and preserve flag into the entry at the slot pointer and marks it valid. The tag readback word for the pointed entry is {valid, preserve, vpn}, with valid in the top bit. The data readback word is {ppn, attr}, with attr in the low bits.
- R2: A pointer write sets the slot pointer directly. Each load strobe without a pointer write advances it by one, and from the last slot it wraps to the base value rather than to 0.
- R3: A global flush clears the valid bit of every entry whose preserve flag is 0 and leaves preserved entries valid.
- R4: A single-entry flush clears every valid entry whose tag equals the supplied virtual page, whether or not that entry is preserved.
- R5: With translation enabled, an accepted request matching exactly one valid entry produces, on the next cycle, a response with the physical address {ppn, page offset} and the fault flag low.
- R6: With translation enabled, an accepted request matching no entry gives a faulting response with address 0. It sets status bit 0 (miss) and latches the request address on the fault address output.
- R7: With translation enabled, an accepted request matching two or more valid entries gives a faulting response. It sets status bit 1 (multi-hit) and latches the request address.
- R8: While any status bit is set, the ready output is low, requests are ignored and no response is produced. The status bits are write-1-to-clear, and ready returns high on the cycle after the last pending bit is cleared.
- R9: With translation disabled, the response address equals the request address, the fault flag is low and no status bit is set.
- R10: The interrupt output is high exactly when some status bit is set and its enable bit is set. Enable bit 0 masks the miss fault and enable bit 1 masks the multi-hit fault.
- R11: When a load strobe coincides with a global or single-entry flush, the loaded entry ends valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable |
| base_i | input | IDX_W | Number of protected low slots |
| ptr_wr_i | input | 1 | Slot pointer write strobe |
| ptr_val_i | input | IDX_W | Value for the slot pointer |
| ptr_o | output | IDX_W | Current slot pointer |
| st_vpn_i | input | VPN_W | Staged virtual page tag |
| st_ppn_i | input | PPN_W | Staged physical page number |
| st_attr_i | input | ATTR_W | Staged attribute bits |
| st_keep_i | input | 1 | Staged preserve flag |
| load_i | input | 1 | Load strobe |
| gflush_i | input | 1 | Global flush strobe |
| eflush_i | input | 1 | Single-entry flush strobe |
| eflush_vpn_i | input | VPN_W | Virtual page to flush |
| tag_o | output | VPN_W+2 | Tag readback {valid, preserve, vpn} |
| data_o | output | PPN_W+ATTR_W | Data readback {ppn, attr} |
| irq_en_i | input | 2 | Fault interrupt enables |
| fault_clr_i | input | 2 | Write-1-to-clear for status bits |
| fault_o | output | 2 | Status: bit 0 miss, bit 1 multi-hit |
| fault_va_o | output | VA_W | Latched faulting address |
| irq_o | output | 1 | Fault interrupt |
| req_valid_i | input | 1 | Lookup request valid |
| req_va_i | input | VA_W | Lookup virtual address |
| req_ready_o | output | 1 | Lookup request accepted when high |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_pa_o | output | PA_W | Response physical address |
| rsp_fault_o | output | 1 | Response is a fault |

## Verification
The bench makes the pointer rotation reach the last slot with a non-zero base. A design that wraps to 0 would leave the pointer on a protected slot. It loads a duplicate tag to force a multi-hit, which a priority-encoding design would wrongly answer with one of the two page numbers. It issues a request while a fault is pending: a design that does not stall returns an extra response, and the scoreboard flags it as unexpected. It also flushes a preserved entry by address, then flushes globally with mixed preserve flags, and finally loads during a flush. These steps catch designs that honour the preserve flag in the wrong flush, or that let the flush override the load.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned FLT_W     = 2;
  localparam int unsigned FLT_MISS  = 0;
  localparam int unsigned FLT_MULTI = 1;

  typedef enum logic [1:0] {
    LK_BYPASS = 2'd0,
    LK_HIT    = 2'd1,
    LK_MISS   = 2'd2,
    LK_MULTI  = 2'd3
  } lk_kind_e;
endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ATTR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [VPN_W-1:0]   st_vpn_i,
  input  logic [PPN_W-1:0]   st_ppn_i,
  input  logic [ATTR_W-1:0]  st_attr_i,
  input  logic               st_keep_i,
  input  logic               gflush_i,
  input  logic               eflush_i,
  input  logic [VPN_W-1:0]   eflush_vpn_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               rd_valid_o,
  output logic               rd_keep_o,
  output logic [VPN_W-1:0]   rd_vpn_o,
  output logic [PPN_W-1:0]   rd_ppn_o,
  output logic [ATTR_W-1:0]  rd_attr_o,
  output logic [ENTRIES-1:0] match_o,
  output logic [PPN_W-1:0]   ppn_sel_o
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] keep_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      keep_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        // load has priority over both flush kinds on its own slot
        if (ld_i && (idx_i == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          keep_q[i]  <= st_keep_i;
          vpn_q[i]   <= st_vpn_i;
          ppn_q[i]   <= st_ppn_i;
          attr_q[i]  <= st_attr_i;
        end else if ((gflush_i && !keep_q[i]) ||
                     (eflush_i && (vpn_q[i] == eflush_vpn_i))) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  always_comb begin
    ppn_sel_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) ppn_sel_o = ppn_sel_o | ppn_q[i];
    end
  end

  assign rd_valid_o = valid_q[idx_i];
  assign rd_keep_o  = keep_q[idx_i];
  assign rd_vpn_o   = vpn_q[idx_i];
  assign rd_ppn_o   = ppn_q[idx_i];
  assign rd_attr_o  = attr_q[idx_i];

  function automatic logic any_valid_tag(input logic [VPN_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && (vpn_q[i] == v)) r = 1'b1;
    end
    return r;
  endfunction

  assert_load_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> valid_q[$past(idx_i)]);

  assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && (gflush_i || eflush_i)) |=> valid_q[$past(idx_i)]);

  assert_gflush_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gflush_i && !ld_i && !eflush_i) |=> (valid_q == $past(valid_q & keep_q)));

  assert_eflush_gone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eflush_i && !ld_i) |=> !any_valid_tag($past(eflush_vpn_i)));

endmodule

// File: rtl/tlb_victim_ptr.sv
`timescale 1ns/1ps
module tlb_victim_ptr #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_wr_i,
  input  logic [IDX_W-1:0] ptr_val_i,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_nxt;

  // rotation never re-enters the protected range below base
  always_comb ptr_nxt = (ptr_q == LAST) ? base_i : ptr_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (ptr_wr_i) ptr_q <= ptr_val_i;
    else if (ld_i)     ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  assert_wrap_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !ptr_wr_i && (ptr_q == LAST)) |=> (ptr_q == $past(base_i)));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !ptr_wr_i && (ptr_q != LAST)) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));

  assert_base_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(base_i) < ENTRIES);

endmodule

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 32,
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_OFF_W = 12,
  parameter int unsigned PPN_W    = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic [ENTRIES-1:0] match_i,
  input  logic [PPN_W-1:0]   ppn_i,
  input  logic [FLT_W-1:0]   ie_i,
  input  logic [FLT_W-1:0]   clr_i,
  output logic               req_ready_o,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic               rsp_fault_o,
  output logic [FLT_W-1:0]   status_o,
  output logic [VA_W-1:0]    fault_va_o,
  output logic               irq_o
);

  logic             fire, none, multi;
  lk_kind_e         kind;
  logic [FLT_W-1:0] status_q, status_d;
  logic [VA_W-1:0]  fault_va_q;
  logic             rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]  rsp_pa_q;

  assign req_ready_o = ~|status_q;
  assign fire        = req_valid_i && req_ready_o;
  assign none        = ~|match_i;
  assign multi       = |(match_i & (match_i - ENTRIES'(1)));

  always_comb begin
    if (!en_i)      kind = LK_BYPASS;
    else if (none)  kind = LK_MISS;
    else if (multi) kind = LK_MULTI;
    else            kind = LK_HIT;
  end

  always_comb begin
    status_d = status_q & ~clr_i;
    if (fire && (kind == LK_MISS))  status_d[FLT_MISS]  = 1'b1;
    if (fire && (kind == LK_MULTI)) status_d[FLT_MULTI] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      fault_va_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_pa_q    <= '0;
    end else begin
      status_q    <= status_d;
      rsp_valid_q <= fire;
      if (fire) begin
        unique case (kind)
          LK_BYPASS: begin rsp_pa_q <= PA_W'(req_va_i); rsp_fault_q <= 1'b0; end
          LK_HIT: begin
            rsp_pa_q    <= {ppn_i, req_va_i[PG_OFF_W-1:0]};
            rsp_fault_q <= 1'b0;
          end
          default: begin
            rsp_pa_q    <= '0;
            rsp_fault_q <= 1'b1;
            fault_va_q  <= req_va_i;
          end
        endcase
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_pa_o    = rsp_pa_q;
  assign rsp_fault_o = rsp_fault_q;
  assign status_o    = status_q;
  assign fault_va_o  = fault_va_q;
  assign irq_o       = |(status_q & ie_i);

  assert_hit_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && en_i && $onehot(match_i)) |=> (rsp_valid_o && !rsp_fault_o));

  assert_miss_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && en_i && none) |=> (status_o[FLT_MISS] && fault_va_o == $past(req_va_i)));

  assert_multi_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && en_i && ($countones(match_i) > 1)) |=> (status_o[FLT_MULTI] && rsp_fault_o));

  assert_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o) |=> !rsp_valid_o);

  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !en_i) |=> (rsp_valid_o && !rsp_fault_o && rsp_pa_o == PA_W'($past(req_va_i))));

  assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_o));

endmodule

// File: rtl/sw_tlb.sv
`timescale 1ns/1ps
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 32,
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_OFF_W = 12,
  parameter int unsigned ATTR_W   = 4,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned VPN_W   = VA_W - PG_OFF_W,
  localparam int unsigned PPN_W   = PA_W - PG_OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xlat_en_i,
  input  logic [IDX_W-1:0]        base_i,
  input  logic                    ptr_wr_i,
  input  logic [IDX_W-1:0]        ptr_val_i,
  output logic [IDX_W-1:0]        ptr_o,
  input  logic [VPN_W-1:0]        st_vpn_i,
  input  logic [PPN_W-1:0]        st_ppn_i,
  input  logic [ATTR_W-1:0]       st_attr_i,
  input  logic                    st_keep_i,
  input  logic                    load_i,
  input  logic                    gflush_i,
  input  logic                    eflush_i,
  input  logic [VPN_W-1:0]        eflush_vpn_i,
  output logic [VPN_W+1:0]        tag_o,
  output logic [PPN_W+ATTR_W-1:0] data_o,
  input  logic [1:0]              irq_en_i,
  input  logic [1:0]              fault_clr_i,
  output logic [1:0]              fault_o,
  output logic [VA_W-1:0]         fault_va_o,
  output logic                    irq_o,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_va_i,
  output logic                    req_ready_o,
  output logic                    rsp_valid_o,
  output logic [PA_W-1:0]         rsp_pa_o,
  output logic                    rsp_fault_o
);

  logic [IDX_W-1:0]   ptr;
  logic               rd_valid, rd_keep;
  logic [VPN_W-1:0]   rd_vpn;
  logic [PPN_W-1:0]   rd_ppn, ppn_sel;
  logic [ATTR_W-1:0]  rd_attr;
  logic [ENTRIES-1:0] match;

  tlb_victim_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk_i, .rst_ni,
    .ptr_wr_i, .ptr_val_i,
    .ld_i   (load_i),
    .base_i,
    .ptr_o  (ptr)
  );

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)
  ) u_arr (
    .clk_i, .rst_ni,
    .ld_i        (load_i),
    .idx_i       (ptr),
    .st_vpn_i, .st_ppn_i, .st_attr_i, .st_keep_i,
    .gflush_i, .eflush_i, .eflush_vpn_i,
    .lk_vpn_i    (req_va_i[VA_W-1:PG_OFF_W]),
    .rd_valid_o  (rd_valid),
    .rd_keep_o   (rd_keep),
    .rd_vpn_o    (rd_vpn),
    .rd_ppn_o    (rd_ppn),
    .rd_attr_o   (rd_attr),
    .match_o     (match),
    .ppn_sel_o   (ppn_sel)
  );

  tlb_lookup #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PG_OFF_W(PG_OFF_W), .PPN_W(PPN_W)
  ) u_lk (
    .clk_i, .rst_ni,
    .en_i        (xlat_en_i),
    .req_valid_i, .req_va_i,
    .match_i     (match),
    .ppn_i       (ppn_sel),
    .ie_i        (irq_en_i),
    .clr_i       (fault_clr_i),
    .req_ready_o, .rsp_valid_o, .rsp_pa_o, .rsp_fault_o,
    .status_o    (fault_o),
    .fault_va_o, .irq_o
  );

  assign ptr_o  = ptr;
  assign tag_o  = {rd_valid, rd_keep, rd_vpn};
  assign data_o = {rd_ppn, rd_attr};

endmodule

// File: tb/sw_tlb_tb_top.sv
`timescale 1ns/1ps
module sw_tlb_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlat_en_i = 1'b0;
  logic [4:0]  base_i = '0;
  logic        ptr_wr_i = 1'b0;
  logic [4:0]  ptr_val_i = '0;
  logic [4:0]  ptr_o;
  logic [19:0] st_vpn_i = '0;
  logic [19:0] st_ppn_i = '0;
  logic [3:0]  st_attr_i = '0;
  logic        st_keep_i = 1'b0;
  logic        load_i = 1'b0;
  logic        gflush_i = 1'b0;
  logic        eflush_i = 1'b0;
  logic [19:0] eflush_vpn_i = '0;
  logic [21:0] tag_o;
  logic [23:0] data_o;
  logic [1:0]  irq_en_i = '0;
  logic [1:0]  fault_clr_i = '0;
  logic [1:0]  fault_o;
  logic [31:0] fault_va_o;
  logic        irq_o;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_ready_o;
  logic        rsp_valid_o;
  logic [31:0] rsp_pa_o;
  logic        rsp_fault_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed { logic [31:0] pa; logic fault; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  sw_tlb dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: every response must match the oldest expected item
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected response", 64'(rsp_pa_o), 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5/R6/R7/R9 rsp_pa", 64'(rsp_pa_o), 64'(e.pa));
        chk("R5/R6/R7/R9 rsp_fault", 64'(rsp_fault_o), 64'(e.fault));
      end
    end
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic set_ptr(input logic [4:0] v);
    ptr_wr_i = 1'b1; ptr_val_i = v; tick(); ptr_wr_i = 1'b0;
  endtask

  task automatic load_ent(input logic [19:0] vpn, input logic [19:0] ppn,
                          input logic [3:0] attr, input logic keep);
    st_vpn_i = vpn; st_ppn_i = ppn; st_attr_i = attr; st_keep_i = keep;
    load_i = 1'b1; tick(); load_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [31:0] pa, input logic flt);
    exp_t e;
    e.pa = pa; e.fault = flt;
    exp_q.push_back(e);
    req_valid_i = 1'b1; req_va_i = va; tick(); req_valid_i = 1'b0;
    tick();
  endtask

  task automatic clear(input logic [1:0] v);
    fault_clr_i = v; tick(); fault_clr_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..R11 act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); rst_ni = 1'b1; tick();
    settle();
    chk("R8 reset ready", 64'(req_ready_o), 64'd1);
    chk("R6 reset status", 64'(fault_o), 64'd0);
    chk("R2 reset ptr", 64'(ptr_o), 64'd0);
    chk("R1 reset tag", 64'(tag_o), 64'd0);
    chk("R10 reset irq", 64'(irq_o), 64'd0);

    base_i = 5'd4;
    set_ptr(5'd0);
    for (int k = 0; k < 6; k++) begin
      load_ent(20'h100 + 20'(k), 20'h500 + 20'(k), 4'(k), k < 2);
      settle();
      chk("R2 ptr step", 64'(ptr_o), 64'(k + 1));
    end
    set_ptr(5'd2); settle();
    chk("R1 tag word", 64'(tag_o), 64'({1'b1, 1'b0, 20'h102}));
    chk("R1 data word", 64'(data_o), 64'({20'h502, 4'h2}));
    set_ptr(5'd1); settle();
    chk("R1 preserve in tag", 64'(tag_o), 64'({1'b1, 1'b1, 20'h101}));

    set_ptr(5'd31);
    load_ent(20'h1F0, 20'h7F0, 4'h9, 1'b0);
    settle();
    chk("R2 wrap to base", 64'(ptr_o), 64'd4);

    xlat_en_i = 1'b1; irq_en_i = 2'b11;
    lookup(32'h0010_2ABC, 32'h0050_2ABC, 1'b0);  // R5
    lookup(32'h0010_5000, 32'h0050_5000, 1'b0);  // R5
    lookup(32'h001F_0FFF, 32'h007F_0FFF, 1'b0);  // R5

    xlat_en_i = 1'b0;
    lookup(32'hDEAD_B123, 32'hDEAD_B123, 1'b0);  // R9
    settle();
    chk("R9 no status", 64'(fault_o), 64'd0);

    xlat_en_i = 1'b1;
    lookup(32'h0077_7444, 32'h0, 1'b1);          // R6
    settle();
    chk("R6 miss bit", 64'(fault_o), 64'b01);
    chk("R6 fault va", 64'(fault_va_o), 64'h0077_7444);
    chk("R10 irq miss", 64'(irq_o), 64'd1);
    chk("R8 stalled", 64'(req_ready_o), 64'd0);
    req_valid_i = 1'b1; req_va_i = 32'h0010_2000; tick(); req_valid_i = 1'b0; tick();
    settle();
    chk("R8 va held", 64'(fault_va_o), 64'h0077_7444);
    clear(2'b01); settle();
    chk("R8 released", 64'(req_ready_o), 64'd1);
    chk("R8 status clear", 64'(fault_o), 64'd0);
    chk("R10 irq drop", 64'(irq_o), 64'd0);

    irq_en_i = 2'b10;
    lookup(32'h0088_8000, 32'h0, 1'b1);
    settle();
    chk("R10 masked status", 64'(fault_o), 64'b01);
    chk("R10 masked irq", 64'(irq_o), 64'd0);
    irq_en_i = 2'b11; settle();
    chk("R10 unmasked irq", 64'(irq_o), 64'd1);
    clear(2'b01);

    set_ptr(5'd10);
    load_ent(20'h103, 20'h603, 4'h1, 1'b0);
    lookup(32'h0010_3010, 32'h0, 1'b1);          // R7
    settle();
    chk("R7 multi bit", 64'(fault_o), 64'b10);
    chk("R7 fault va", 64'(fault_va_o), 64'h0010_3010);
    clear(2'b11); settle();
    chk("R8 clear multi", 64'(req_ready_o), 64'd1);

    eflush_vpn_i = 20'h100; eflush_i = 1'b1; tick(); eflush_i = 1'b0;
    set_ptr(5'd0); settle();
    chk("R4 preserved flushed", 64'(tag_o[21]), 64'd0);
    lookup(32'h0010_0000, 32'h0, 1'b1);
    clear(2'b01);

    gflush_i = 1'b1; tick(); gflush_i = 1'b0;
    set_ptr(5'd1); settle();
    chk("R3 preserved kept", 64'(tag_o[21]), 64'd1);
    set_ptr(5'd2); settle();
    chk("R3 plain cleared", 64'(tag_o[21]), 64'd0);
    lookup(32'h0010_1AAA, 32'h0050_1AAA, 1'b0);  // R3
    lookup(32'h0010_2000, 32'h0, 1'b1);          // R3
    clear(2'b01);

    set_ptr(5'd20);
    st_vpn_i = 20'h2AA; st_ppn_i = 20'h3BB; st_attr_i = 4'h5; st_keep_i = 1'b0;
    load_i = 1'b1; gflush_i = 1'b1; eflush_i = 1'b1; eflush_vpn_i = 20'h2AA;
    tick();
    load_i = 1'b0; gflush_i = 1'b0; eflush_i = 1'b0;
    set_ptr(5'd20); settle();
    chk("R11 load wins", 64'(tag_o), 64'({1'b1, 1'b0, 20'h2AA}));
    lookup(32'h002A_A123, 32'h003B_B123, 1'b0);  // R11

    tick(); tick(); settle();
    chk("R5 queue drained", 64'(exp_q.size()), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule